// File: doc/BRIEF.md
# Timer Waveform Generator with Forced Compare

A 16-bit timer whose counter advances by one step on each clock cycle where the count-enable input is high. A 4-bit mode code selects how the counter moves and where its ceiling (TOP) comes from. It can free-run over the full range, clear on a compare value, saw-tooth up to a TOP value, or rise to TOP and fall back to zero (dual slope). A single compare channel drives one output pin. A 2-bit output-mode code decides whether the pin toggles, clears or sets on a match, or is driven as a PWM level. Two one-cycle event outputs report compare matches and overflows to an interrupt controller outside the block.

The counter direction is held in a two-state machine. COUNT_UP moves to COUNT_DOWN on the step that reaches TOP in a dual-slope mode ("turn at TOP"). COUNT_DOWN moves back to COUNT_UP on the step taken at zero ("turn at BOTTOM"). Reset, or any mode that is not dual slope, returns the machine to COUNT_UP ("leave dual slope").

In the PWM modes the compare value and the capture value used as TOP are double-buffered. Each mode class copies them in at its own update point. A force strobe lets software apply the selected pin action at once while a non-PWM mode is active. The strobe leaves the counter and the event outputs untouched.

Top module: `wavegen_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `count` is 0, `wave_out` is 0, `match_evt` is 0 and `ovf_evt` is 0.
- R2: `count` changes only at a clock edge where `tick` is high. In normal mode (code 0x0, and every code not named in R3 to R5 or R10), each such step adds one. A step from 0xFFFF goes to 0 and raises an overflow event.
- R3: In mode 0xC, a step taken while `count` equals the live `cmp_a` value moves `count` to 0. Otherwise the step adds one. An overflow event occurs only on a step from 0xFFFF.
- R4: Fast PWM: mode 0x7 uses TOP = 0x3FF, mode 0xE uses the buffered `cap_top` and mode 0xF uses the buffered `cmp_a`. A step taken while `count` >= TOP moves `count` to 0 and raises an overflow event. Otherwise the step adds one.
- R5: Dual slope: modes 0x8 and 0x9 are phase-and-frequency correct and modes 0xA and 0xB are phase correct. Modes 0x8 and 0xA take TOP from the buffered `cap_top`; modes 0x9 and 0xB take it from the buffered `cmp_a`. In COUNT_UP, a step at `count` >= TOP goes to COUNT_DOWN with `count`-1 (0 stays 0); otherwise the step adds one. In COUNT_DOWN, a step at 0 raises an overflow event and goes to COUNT_UP with 1 (or 0 when TOP is 0); otherwise the step subtracts one.
- R6: In the PWM modes, `out_mode` 2 is non-inverting and 3 is inverting. With mode 2, fast PWM clears the pin on a match and sets it on a wrap, and the wrap wins when both occur on the same step. Dual slope clears the pin on a match taken in COUNT_UP and sets it on a match taken in COUNT_DOWN. Mode 3 drives the opposite levels. With `out_mode` 0 or 1 the pin holds its level.
- R7: In normal and CTC modes, a step taken while `count` equals `cmp_a` acts on the pin according to `out_mode`: 1 toggles the pin, 2 clears it, 3 sets it, and 0 leaves it unchanged.
- R8: In normal and CTC modes, a cycle with `force_cmp` high applies the R7 pin action even without a step. It raises no event and does not change `count`, even in mode 0xC with `count` equal to `cmp_a`. In the PWM modes `force_cmp` has no effect.
- R9: In the PWM modes, the buffered compare and capture values copy the inputs at these update points: fast PWM on the wrap step, phase-correct on the turn-at-TOP step, and phase-and-frequency correct on the turn-at-BOTTOM step. The copied values take effect from the next cycle. In non-PWM modes the buffers follow the inputs every cycle.
- R10: The reserved code 0xD behaves exactly as normal mode.
- R11: `match_evt` is high for exactly the cycle after a step whose pre-step `count` equals the compare value in use. `ovf_evt` is high for exactly the cycle after a step that raised an overflow. Neither output is ever high after a cycle without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse; one counter step per high cycle |
| wave_mode | input | 4 | Waveform mode code |
| out_mode | input | 2 | Compare-output action code |
| cmp_a | input | 16 | Compare value (also TOP in 0x9, 0xB, 0xC, 0xF) |
| cap_top | input | 16 | Capture value used as TOP in 0x8, 0xA, 0xE |
| force_cmp | input | 1 | Force-compare strobe |
| count | output | 16 | Counter value |
| wave_out | output | 1 | Compare output pin level |
| match_evt | output | 1 | Compare-match event pulse |
| ovf_evt | output | 1 | Overflow event pulse |

## Verification
The hardest situation to reach is a change of the compare or capture input in the middle of a dual-slope period. It shows the difference between the turn-at-TOP and turn-at-BOTTOM update points only when the new value lands between them. The stimulus rewrites `cap_top` and `cmp_a` at several odd offsets into running phase-correct and phase-and-frequency-correct periods, and lowers TOP below the present count. The reference model decides when each value becomes active. A forced compare is also issued in mode 0xC while `cmp_a` is set equal to the live count, so that a wrongly cleared counter would show at once.

// File: rtl/wg_pkg.sv
package wg_pkg;
    typedef enum logic [2:0] {
        CLS_NORMAL,
        CLS_CTC,
        CLS_FAST,
        CLS_PHASE,
        CLS_PFC
    } wg_class_e;

    typedef enum logic [1:0] {
        TOP_FULL,
        TOP_FIXED,
        TOP_CAP,
        TOP_CMP
    } wg_top_e;

    typedef struct packed {
        wg_class_e cls;
        wg_top_e   top;
    } wg_mode_t;

    typedef enum logic {
        COUNT_UP,
        COUNT_DOWN
    } wg_dir_e;
endpackage

// File: rtl/wg_mode_decode.sv
module wg_mode_decode
    import wg_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode_code,
    output wg_mode_t          mode
);
    always_comb begin
        unique case (mode_code)
            MODE_W'(4'h7): mode = '{cls: CLS_FAST,  top: TOP_FIXED};
            MODE_W'(4'h8): mode = '{cls: CLS_PFC,   top: TOP_CAP};
            MODE_W'(4'h9): mode = '{cls: CLS_PFC,   top: TOP_CMP};
            MODE_W'(4'hA): mode = '{cls: CLS_PHASE, top: TOP_CAP};
            MODE_W'(4'hB): mode = '{cls: CLS_PHASE, top: TOP_CMP};
            MODE_W'(4'hC): mode = '{cls: CLS_CTC,   top: TOP_CMP};
            MODE_W'(4'hE): mode = '{cls: CLS_FAST,  top: TOP_CAP};
            MODE_W'(4'hF): mode = '{cls: CLS_FAST,  top: TOP_CMP};
            default:       mode = '{cls: CLS_NORMAL, top: TOP_FULL};
        endcase
    end
endmodule

// File: rtl/wg_counter.sv
module wg_counter
    import wg_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int FIXED_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wg_mode_t         mode,
    input  logic [CNT_W-1:0] cmp_live,
    input  logic [CNT_W-1:0] cap_live,
    output logic [CNT_W-1:0] count,
    output wg_dir_e          dir,
    output logic             hit,
    output logic             wrap,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_TOP  = '1;
    localparam logic [CNT_W-1:0] FIXED_TOP = CNT_W'((1 << FIXED_W) - 1);

    logic [CNT_W-1:0] cmp_buf, cap_buf, cmp_eff, cap_eff, top_eff, cnt_nx;
    logic             pwm, dual, load;
    wg_dir_e          dir_nx;

    assign dual = (mode.cls == CLS_PHASE) || (mode.cls == CLS_PFC);
    assign pwm  = dual || (mode.cls == CLS_FAST);

    // In PWM modes the buffered copies are active; otherwise the live inputs
    assign cmp_eff = pwm ? cmp_buf : cmp_live;
    assign cap_eff = pwm ? cap_buf : cap_live;

    always_comb begin
        unique case (mode.top)
            TOP_FIXED: top_eff = FIXED_TOP;
            TOP_CAP:   top_eff = cap_eff;
            TOP_CMP:   top_eff = cmp_eff;
            default:   top_eff = FULL_TOP;
        endcase
    end

    assign hit = tick && (count == cmp_eff);

    // Next count, direction and update point
    always_comb begin
        cnt_nx = count;
        dir_nx = dual ? dir : COUNT_UP;
        wrap   = 1'b0;
        ovf    = 1'b0;
        load   = 1'b0;
        if (tick) begin
            unique case (mode.cls)
                CLS_CTC: begin
                    cnt_nx = (count == cmp_eff) ? '0 : count + 1'b1;
                    ovf    = (count == FULL_TOP);
                end
                CLS_FAST: begin
                    if (count >= top_eff) begin
                        cnt_nx = '0;
                        wrap   = 1'b1;
                        ovf    = 1'b1;
                        load   = 1'b1;
                    end else begin
                        cnt_nx = count + 1'b1;
                    end
                end
                CLS_PHASE, CLS_PFC: begin
                    unique case (dir)
                        COUNT_UP: begin
                            if (count >= top_eff) begin
                                cnt_nx = (count == '0) ? '0 : count - 1'b1;
                                dir_nx = COUNT_DOWN;
                                load   = (mode.cls == CLS_PHASE);
                            end else begin
                                cnt_nx = count + 1'b1;
                            end
                        end
                        COUNT_DOWN: begin
                            if (count == '0) begin
                                cnt_nx = (top_eff == '0) ? '0 : CNT_W'(1);
                                dir_nx = COUNT_UP;
                                ovf    = 1'b1;
                                load   = (mode.cls == CLS_PFC);
                            end else begin
                                cnt_nx = count - 1'b1;
                            end
                        end
                        default: cnt_nx = count;
                    endcase
                end
                default: begin
                    cnt_nx = count + 1'b1;
                    ovf    = (count == FULL_TOP);
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= COUNT_UP;
            count   <= '0;
            cmp_buf <= '0;
            cap_buf <= '0;
        end else begin
            dir   <= dir_nx;
            count <= cnt_nx;
            if (!pwm || load) begin
                cmp_buf <= cmp_live;
                cap_buf <= cap_live;
            end
        end
    end
endmodule

// File: rtl/wg_pin_ctl.sv
module wg_pin_ctl
    import wg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wg_class_e cls,
    input  logic [1:0] out_mode,
    input  wg_dir_e   dir,
    input  logic      hit,
    input  logic      wrap,
    input  logic      ovf,
    input  logic      force_cmp,
    output logic      wave_out,
    output logic      match_evt,
    output logic      ovf_evt
);
    logic pin_nx, inv;

    assign inv = out_mode[0];

    always_comb begin
        pin_nx = wave_out;
        unique case (cls)
            CLS_FAST: begin
                if (out_mode[1]) begin
                    if (wrap)     pin_nx = ~inv;
                    else if (hit) pin_nx = inv;
                end
            end
            CLS_PHASE, CLS_PFC: begin
                if (out_mode[1] && hit)
                    pin_nx = (dir == COUNT_UP) ? inv : ~inv;
            end
            default: begin
                if (hit || force_cmp) begin
                    unique case (out_mode)
                        2'd1:    pin_nx = ~wave_out;
                        2'd2:    pin_nx = 1'b0;
                        2'd3:    pin_nx = 1'b1;
                        default: pin_nx = wave_out;
                    endcase
                end
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_out  <= 1'b0;
            match_evt <= 1'b0;
            ovf_evt   <= 1'b0;
        end else begin
            wave_out  <= pin_nx;
            match_evt <= hit;
            ovf_evt   <= ovf;
        end
    end
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
    import wg_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MODE_W  = 4,
    parameter int FIXED_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic [1:0]        out_mode,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cap_top,
    input  logic              force_cmp,
    output logic [CNT_W-1:0]  count,
    output logic              wave_out,
    output logic              match_evt,
    output logic              ovf_evt
);
    wg_mode_t mode;
    wg_dir_e  dir;
    logic     hit, wrap, ovf;

    wg_mode_decode #(.MODE_W(MODE_W)) u_decode (
        .mode_code (wave_mode),
        .mode      (mode)
    );

    wg_counter #(.CNT_W(CNT_W), .FIXED_W(FIXED_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .cmp_live (cmp_a),
        .cap_live (cap_top),
        .count    (count),
        .dir      (dir),
        .hit      (hit),
        .wrap     (wrap),
        .ovf      (ovf)
    );

    wg_pin_ctl u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (mode.cls),
        .out_mode  (out_mode),
        .dir       (dir),
        .hit       (hit),
        .wrap      (wrap),
        .ovf       (ovf),
        .force_cmp (force_cmp),
        .wave_out  (wave_out),
        .match_evt (match_evt),
        .ovf_evt   (ovf_evt)
    );
endmodule

// File: rtl/wg_timer_checker.sv
module wg_timer_checker #(
    parameter int CNT_W   = 16,
    parameter int MODE_W  = 4,
    parameter int FIXED_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [MODE_W-1:0] wave_mode,
    input logic [CNT_W-1:0]  cmp_a,
    input logic [CNT_W-1:0]  count,
    input logic              wave_out,
    input logic              match_evt,
    input logic              ovf_evt
);
    localparam logic [CNT_W-1:0] FIXED_TOP = CNT_W'((1 << FIXED_W) - 1);

    logic is_pwm;
    assign is_pwm = (wave_mode >= MODE_W'(4'h7)) && (wave_mode != MODE_W'(4'hC))
                    && (wave_mode != MODE_W'(4'hD));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !wave_out && !match_evt && !ovf_evt));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    assert_ctc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == MODE_W'(4'hC) && count == cmp_a) |=> (count == '0));

    assert_fixed_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == MODE_W'(4'h7) && count >= FIXED_TOP) |=> (count == '0 && ovf_evt));

    assert_pwm_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !tick) |=> $stable(wave_out));

    assert_reserved_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wave_mode == MODE_W'(4'hD)) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_no_event_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!match_evt && !ovf_evt));
endmodule

bind wavegen_timer wg_timer_checker #(
    .CNT_W(CNT_W), .MODE_W(MODE_W), .FIXED_W(FIXED_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wave_mode (wave_mode),
    .cmp_a     (cmp_a),
    .count     (count),
    .wave_out  (wave_out),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt)
);

// File: tb/test_wavegen_timer.sv
module test_wavegen_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  wave_mode = 4'h0;
    logic [1:0]  out_mode = 2'd0;
    logic [15:0] cmp_a = 16'd0;
    logic [15:0] cap_top = 16'd0;
    logic        force_cmp = 1'b0;
    logic [15:0] count;
    logic        wave_out, match_evt, ovf_evt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0, m_dir = 0, m_cbuf = 0, m_tbuf = 0;
    bit m_pin = 0, m_mev = 0, m_oev = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wavegen_timer i_wavegen_timer (
        .clk (clk), .rst_n (rst_n), .tick (tick), .wave_mode (wave_mode),
        .out_mode (out_mode), .cmp_a (cmp_a), .cap_top (cap_top),
        .force_cmp (force_cmp), .count (count), .wave_out (wave_out),
        .match_evt (match_evt), .ovf_evt (ovf_evt)
    );

    // Behavioural reference, evaluated from the requirement text
    always @(posedge clk) begin
        int md, cmpv, capv, topv, n, nd;
        bit pwm, dual, fast, hit, ovf, ld, p, inv;
        if (!rst_n) begin
            m_cnt = 0; m_dir = 0; m_cbuf = 0; m_tbuf = 0;
            m_pin = 0; m_mev = 0; m_oev = 0;
        end else begin
            md   = int'(wave_mode);
            dual = (md >= 8 && md <= 11);
            fast = (md == 7 || md == 14 || md == 15);
            pwm  = dual || fast;
            cmpv = pwm ? m_cbuf : int'(cmp_a);
            capv = pwm ? m_tbuf : int'(cap_top);
            if (md == 7) topv = 1023;
            else if (md == 8 || md == 10 || md == 14) topv = capv;
            else if (md == 9 || md == 11 || md == 12 || md == 15) topv = cmpv;
            else topv = 65535;
            hit = tick && (m_cnt == cmpv);
            ovf = 0; ld = 0; n = m_cnt; nd = dual ? m_dir : 0; p = m_pin;
            if (tick) begin
                if (fast) begin
                    if (m_cnt >= topv) begin n = 0; ovf = 1; ld = 1; end
                    else n = m_cnt + 1;
                end else if (dual) begin
                    if (m_dir == 0) begin
                        if (m_cnt >= topv) begin
                            n = (m_cnt == 0) ? 0 : m_cnt - 1; nd = 1; ld = (md >= 10);
                        end else n = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin
                            n = (topv == 0) ? 0 : 1; nd = 0; ovf = 1; ld = (md <= 9);
                        end else n = m_cnt - 1;
                    end
                end else begin
                    if (md == 12 && m_cnt == cmpv) n = 0;
                    else n = (m_cnt + 1) % 65536;
                    ovf = (m_cnt == 65535);
                end
            end
            if (!pwm) begin
                if (hit || force_cmp) begin
                    if (out_mode == 1) p = !m_pin;
                    else if (out_mode == 2) p = 0;
                    else if (out_mode == 3) p = 1;
                end
            end else if (out_mode >= 2) begin
                inv = (out_mode == 3);
                if (fast) begin
                    if (ovf) p = !inv;
                    else if (hit) p = inv;
                end else if (hit) p = (m_dir == 0) ? inv : !inv;
            end
            if (!pwm || ld) begin m_cbuf = int'(cmp_a); m_tbuf = int'(cap_top); end
            m_cnt = n; m_dir = nd; m_pin = p; m_mev = hit; m_oev = ovf;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        checks++;
        if (count !== m_cnt[15:0] || wave_out !== m_pin ||
            match_evt !== m_mev || ovf_evt !== m_oev) begin
            errors++;
            $display("FAIL %s cycle %0d: actual count=%0d pin=%0b mev=%0b oev=%0b expected count=%0d pin=%0b mev=%0b oev=%0b",
                     tag, cyc, count, wave_out, match_evt, ovf_evt, m_cnt, m_pin, m_mev, m_oev);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input int n, input int every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ((i % every) == 0);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic strobe_force();
        @(negedge clk); force_cmp = 1'b1;
        @(negedge clk); force_cmp = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); tag = "R1"; rst_n = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: normal counting, sparse and dense ticks
        tag = "R2"; wave_mode = 4'h0; cmp_a = 16'h0040; out_mode = 2'd1;
        run(300, 3);
        // R7: match actions in normal mode
        tag = "R7"; out_mode = 2'd2; run(200, 1);
        out_mode = 2'd3; run(200, 1);
        out_mode = 2'd0; run(200, 1);
        // R2: full-range wrap with overflow
        tag = "R2"; out_mode = 2'd1; run(65600, 1);
        // R10: reserved code acts as normal
        tag = "R10"; wave_mode = 4'hD; cmp_a = 16'd1000; run(400, 1);

        // R3: CTC
        do_reset();
        tag = "R3"; wave_mode = 4'hC; cmp_a = 16'd5; out_mode = 2'd1; run(40, 1);
        out_mode = 2'd2; run(20, 1);
        out_mode = 2'd3; run(20, 1);
        out_mode = 2'd1; run(30, 2);
        cmp_a = 16'd9; run(40, 1);

        // R8: forced compare in non-PWM modes
        tag = "R8"; out_mode = 2'd1; strobe_force(); strobe_force(); strobe_force();
        cmp_a = m_cnt[15:0]; strobe_force();
        out_mode = 2'd2; strobe_force();
        out_mode = 2'd3; strobe_force();
        run(5, 1);
        wave_mode = 4'h0; out_mode = 2'd1; strobe_force(); strobe_force();

        // R4: fast PWM with each TOP source
        do_reset();
        tag = "R4"; wave_mode = 4'h7; out_mode = 2'd2; cmp_a = 16'd300; cap_top = 16'd20;
        run(2200, 1);
        wave_mode = 4'hE; cmp_a = 16'd12; out_mode = 2'd3; run(100, 1);
        wave_mode = 4'hF; cmp_a = 16'd15; out_mode = 2'd2; run(100, 2);

        // R5: dual-slope modes, including TOP of zero
        do_reset();
        tag = "R5"; wave_mode = 4'h8; cap_top = 16'd30; cmp_a = 16'd10; out_mode = 2'd2;
        run(200, 1);
        wave_mode = 4'h9; cmp_a = 16'd25; out_mode = 2'd3; run(200, 1);
        wave_mode = 4'hA; cap_top = 16'd40; run(200, 1);
        wave_mode = 4'hB; cmp_a = 16'd17; out_mode = 2'd2; run(200, 1);
        cmp_a = 16'd0; run(40, 1);

        // R6: PWM pin codes, including the holding codes
        tag = "R6"; wave_mode = 4'hA; cap_top = 16'd16; cmp_a = 16'd6; out_mode = 2'd3;
        run(100, 1);
        out_mode = 2'd0; run(100, 1);
        out_mode = 2'd1; run(100, 1);
        wave_mode = 4'hE; out_mode = 2'd2; run(80, 1);
        // R8: force ignored in PWM modes
        tag = "R8"; out_mode = 2'd1; strobe_force();
        out_mode = 2'd2; strobe_force(); strobe_force();

        // R9: mid-period changes of buffered values
        do_reset();
        tag = "R9"; wave_mode = 4'h8; cap_top = 16'd30; cmp_a = 16'd8; out_mode = 2'd2;
        run(45, 1); cap_top = 16'd12; run(23, 1); cmp_a = 16'd5; run(70, 1);
        wave_mode = 4'hA; cap_top = 16'd25; run(37, 1); cmp_a = 16'd20; run(29, 1);
        cap_top = 16'd10; run(60, 1);
        wave_mode = 4'hE; cap_top = 16'd18; run(11, 1); cap_top = 16'd7; cmp_a = 16'd3;
        run(60, 1);

        // R11: event pulses under sparse ticks
        tag = "R11"; wave_mode = 4'h0; cmp_a = 16'd40; run(300, 5);
        wave_mode = 4'hF; cmp_a = 16'd9; run(200, 4);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule